// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block runs one complete Serial Wire Debug transaction from the host side. A single `start` pulse captures a request and a configuration. The request is the port select, the read/not-write flag, two address bits, a timestamp flag and 32 bits of write data. The block then generates the whole pin sequence on its own: the 8-bit request packet, the turnaround, the 3-bit acknowledge and the data phase with parity. When it finishes, it pulses `done` and returns a response code. After an OK read it also returns the received word.

The configuration sets the turnaround length (1 to 4 clocks), the number of low idle clocks after a successful transfer, and whether a dummy data phase is clocked after a WAIT or FAULT acknowledge. It also picks the bit rate: either one system clock per half bit, or a programmable number of system clocks per half bit. Retries and the access-port layer belong to the logic that drives `start`.

Top module: `swd_xfer_engine`

## Requirements
- R1: Out of reset and between transfers, `busy` is 0, `swclk` is 1, `swdio_oe` is 1 and `swdio_o` is 1.
- R2: Every bit slot is H system clocks with `swclk` low followed by H clocks with `swclk` high. H is 1 when `cfg_fast` is 1 and `cfg_div`+2 otherwise. The first low clock follows the `start` edge. Drive values change only at the start of a slot. `swdio_i` is sampled on the last low clock of a slot.
- R3: The first 8 slots are driven with, in time order: 1, `req_ap`, `req_rnw`, `req_addr[0]`, `req_addr[1]`, the XOR of those four bits, 0, 1.
- R4: Next come `cfg_turn`+1 released slots (`swdio_oe`=0, and `swdio_o` reads 1 whenever the line is released), then 3 released acknowledge slots. The first acknowledge bit lands in bit 0. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100. `resp` is {1'b0, ack} unless R6 applies.
- R5: On an OK read, 32 released slots capture `rdata` LSB first. One parity slot and then `cfg_turn`+1 released slots follow.
- R6: On an OK read whose parity bit differs from the XOR of the 32 data bits, `resp` is 4'b1000.
- R7: On an OK write, `cfg_turn`+1 released slots come first. Then 32 driven slots carry `wdata` LSB first, followed by a driven slot with the XOR of `wdata`.
- R8: After any OK transfer, `cfg_idle` slots are driven low. A value of 0 adds no slots.
- R9: On WAIT or FAULT with `cfg_dphase`=1 for a read, 33 released slots come before the turnaround.
- R10: On WAIT or FAULT with `cfg_dphase`=1 for a write, 33 driven-low slots follow the turnaround.
- R11: On WAIT or FAULT with `cfg_dphase`=0, only the turnaround follows the acknowledge. No idle slots are added.
- R12: On any other acknowledge value, `cfg_turn`+34 released slots follow the acknowledge.
- R13: `done` is high for exactly the one clock after the last slot, in which `busy` is already 0. `resp` and `rdata` hold until the next completion. A `start` while `busy` is 1 is ignored.
- R14: `ts_strobe` pulses together with `done` when the acknowledge was OK and `req_ts` was 1 at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| req_ap | input | 1 | Port select bit of the request |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Address bits A2 (bit 0) and A3 (bit 1) |
| req_ts | input | 1 | Request a timestamp strobe on OK completion |
| wdata | input | 32 | Write data |
| cfg_turn | input | TURN_W | Turnaround length minus one |
| cfg_idle | input | IDLE_W | Low idle slots after an OK transfer |
| cfg_dphase | input | 1 | Dummy data phase after WAIT/FAULT |
| cfg_fast | input | 1 | One system clock per half bit |
| cfg_div | input | DIV_W | Half-bit length minus two when not fast |
| swdio_i | input | 1 | Data line input |
| swclk | output | 1 | Serial clock to the target |
| swdio_o | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| resp | output | 4 | Response code |
| rdata | output | 32 | Read data of the last OK read |
| ts_strobe | output | 1 | Timestamp capture pulse |

## Verification
Each acknowledge class is driven as a read and as a write. OK reads are driven with correct and with flipped parity, which separates R5 from R6. WAIT and FAULT are driven with the dummy phase on and off, so a dummy phase placed on the wrong side of the turnaround shows up. Acknowledges of 3'b111 and 3'b000 cover the backoff length. Varied turnaround lengths, idle counts, both rate modes and asymmetric data words expose bit-order, length and parity-polarity errors. A `start` pulse in the middle of a transfer checks that it is ignored.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_REQ, PH_TRN_A, PH_ACK, PH_RD, PH_TRN_B,
    PH_WR, PH_DMY_RD, PH_DMY_WR, PH_IDLE_LO, PH_BACKOFF
  } phase_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam logic [3:0] RESP_PERR = 4'b1000;
  localparam int unsigned DATA_SLOTS = 33;

  // even parity of a data word
  function automatic logic word_parity(input logic [31:0] d);
    return ^d;
  endfunction

  // request packet, element i goes out in slot i
  function automatic logic [7:0] req_packet(input logic ap, input logic rnw,
                                            input logic [1:0] a);
    logic p;
    p = ap ^ rnw ^ a[0] ^ a[1];
    return {1'b1, 1'b0, p, a[1], a[0], rnw, ap, 1'b1};
  endfunction

endpackage

// File: rtl/swd_bitclk.sv
module swd_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             run,
  input  logic             fast,
  input  logic [DIV_W-1:0] div,
  output logic             rise,
  output logic             slot_end,
  output logic             clk_hi
);
  localparam int HW = DIV_W + 1;

  logic [HW-1:0] hcnt_q, reload;
  logic          hi_q;

  function automatic logic [HW-1:0] half_minus1(input logic f,
                                                input logic [DIV_W-1:0] d);
    return f ? '0 : ({1'b0, d} + HW'(1));
  endfunction

  assign reload   = half_minus1(fast, div);
  assign rise     = run && (hcnt_q == '0) && !hi_q;
  assign slot_end = run && (hcnt_q == '0) && hi_q;
  assign clk_hi   = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      hi_q   <= 1'b0;
    end else if (go) begin
      hcnt_q <= reload;
      hi_q   <= 1'b0;
    end else if (run) begin
      if (hcnt_q != '0) begin
        hcnt_q <= hcnt_q - HW'(1);
      end else begin
        hcnt_q <= reload;
        hi_q   <= !hi_q;
      end
    end
  end

  // R2
  rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> clk_hi);
  // R2
  end_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !clk_hi);

endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_pkg::*;
#(
  parameter int TURN_W = 2,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic              req_ts,
  input  logic [31:0]       wdata,
  input  logic [TURN_W-1:0] cfg_turn,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              cfg_dphase,
  input  logic              rise,
  input  logic              slot_end,
  input  logic              din,
  output logic              go,
  output logic              busy,
  output logic              drv_oe,
  output logic              drv_o,
  output logic              done,
  output logic [3:0]        resp,
  output logic [31:0]       rdata,
  output logic              ts_strobe
);
  localparam int CNT_W = ((IDLE_W > 6) ? IDLE_W : 6) + 1;

  phase_e              phase_q, nxt;
  logic [CNT_W-1:0]    cnt_q, len;
  logic                ap_q, rnw_q, ts_q, dph_q;
  logic [1:0]          addr_q;
  logic [31:0]         wd_q, rbuf_q;
  logic [TURN_W-1:0]   turn_q;
  logic [IDLE_W-1:0]   idle_q;
  logic [2:0]          ack_q;
  logic                rpar_q;
  logic                last, ok, wf, finish, perr;
  logic [7:0]          pkt;

  function automatic logic [CNT_W-1:0] slot_len(input phase_e p,
                                                input logic [TURN_W-1:0] t,
                                                input logic [IDLE_W-1:0] n);
    logic [CNT_W-1:0] tt;
    tt = CNT_W'(t) + CNT_W'(1);
    case (p)
      PH_REQ:                           return CNT_W'(8);
      PH_TRN_A, PH_TRN_B:               return tt;
      PH_ACK:                           return CNT_W'(3);
      PH_RD, PH_WR, PH_DMY_RD, PH_DMY_WR: return CNT_W'(DATA_SLOTS);
      PH_IDLE_LO:                       return CNT_W'(n);
      PH_BACKOFF:                       return tt + CNT_W'(DATA_SLOTS);
      default:                          return CNT_W'(1);
    endcase
  endfunction

  assign busy   = (phase_q != PH_IDLE);
  assign go     = start && !busy;
  assign len    = slot_len(phase_q, turn_q, idle_q);
  assign last   = (cnt_q == len - CNT_W'(1));
  assign ok     = (ack_q == ACK_OK);
  assign wf     = (ack_q == ACK_WAIT) || (ack_q == ACK_FAULT);
  assign pkt    = req_packet(ap_q, rnw_q, addr_q);
  assign perr   = ok && rnw_q && (rpar_q != word_parity(rbuf_q));
  assign finish = busy && slot_end && last && (nxt == PH_IDLE);

  // phase after the current one completes
  always_comb begin
    phase_e after_ok;
    after_ok = (idle_q != '0) ? PH_IDLE_LO : PH_IDLE;
    case (phase_q)
      PH_REQ:    nxt = PH_TRN_A;
      PH_TRN_A:  nxt = PH_ACK;
      PH_ACK: begin
        if (ok)      nxt = rnw_q ? PH_RD : PH_TRN_B;
        else if (wf) nxt = (dph_q && rnw_q) ? PH_DMY_RD : PH_TRN_B;
        else         nxt = PH_BACKOFF;
      end
      PH_RD:     nxt = PH_TRN_B;
      PH_DMY_RD: nxt = PH_TRN_B;
      PH_TRN_B: begin
        if (ok)                  nxt = rnw_q ? after_ok : PH_WR;
        else if (dph_q && !rnw_q) nxt = PH_DMY_WR;
        else                     nxt = PH_IDLE;
      end
      PH_WR:     nxt = after_ok;
      default:   nxt = PH_IDLE;
    endcase
  end

  // line drive per slot
  always_comb begin
    drv_oe = 1'b0;
    drv_o  = 1'b1;
    case (phase_q)
      PH_IDLE: begin drv_oe = 1'b1; drv_o = 1'b1; end
      PH_REQ:  begin drv_oe = 1'b1; drv_o = pkt[cnt_q[2:0]]; end
      PH_WR: begin
        drv_oe = 1'b1;
        drv_o  = (cnt_q == CNT_W'(32)) ? word_parity(wd_q) : wd_q[cnt_q[4:0]];
      end
      PH_IDLE_LO, PH_DMY_WR: begin drv_oe = 1'b1; drv_o = 1'b0; end
      default: begin drv_oe = 1'b0; drv_o = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      ap_q      <= 1'b0;
      rnw_q     <= 1'b0;
      addr_q    <= '0;
      ts_q      <= 1'b0;
      wd_q      <= '0;
      turn_q    <= '0;
      idle_q    <= '0;
      dph_q     <= 1'b0;
      ack_q     <= '0;
      rbuf_q    <= '0;
      rpar_q    <= 1'b0;
      done      <= 1'b0;
      resp      <= '0;
      rdata     <= '0;
      ts_strobe <= 1'b0;
    end else begin
      done      <= 1'b0;
      ts_strobe <= 1'b0;
      if (go) begin
        ap_q    <= req_ap;
        rnw_q   <= req_rnw;
        addr_q  <= req_addr;
        ts_q    <= req_ts;
        wd_q    <= wdata;
        turn_q  <= cfg_turn;
        idle_q  <= cfg_idle;
        dph_q   <= cfg_dphase;
        ack_q   <= '0;
        rpar_q  <= 1'b0;
        phase_q <= PH_REQ;
        cnt_q   <= '0;
      end else if (busy) begin
        if (rise) begin
          if (phase_q == PH_ACK) ack_q[cnt_q[1:0]] <= din;
          if (phase_q == PH_RD) begin
            if (cnt_q == CNT_W'(32)) rpar_q <= din;
            else                     rbuf_q[cnt_q[4:0]] <= din;
          end
        end
        if (slot_end) begin
          if (!last) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end else begin
            cnt_q   <= '0;
            phase_q <= nxt;
            if (nxt == PH_IDLE) begin
              done      <= 1'b1;
              resp      <= perr ? RESP_PERR : {1'b0, ack_q};
              ts_strobe <= ts_q && ok;
              if (ok && rnw_q) rdata <= rbuf_q;
            end
          end
        end
      end
    end
  end

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done && !busy);
  // R14
  ts_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_strobe |-> done);
  // R6
  perr_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp == RESP_PERR) |-> rnw_q);

endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine #(
  parameter int TURN_W = 2,
  parameter int IDLE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic              req_ts,
  input  logic [31:0]       wdata,
  input  logic [TURN_W-1:0] cfg_turn,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              cfg_dphase,
  input  logic              cfg_fast,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              swdio_i,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  output logic              busy,
  output logic              done,
  output logic [3:0]        resp,
  output logic [31:0]       rdata,
  output logic              ts_strobe
);
  logic go, rise, slot_end, clk_hi;
  logic fast_q;
  logic [DIV_W-1:0] div_q;

  // rate settings held for the whole transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b1;
      div_q  <= '0;
    end else if (go) begin
      fast_q <= cfg_fast;
      div_q  <= cfg_div;
    end
  end

  swd_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .run      (busy),
    .fast     (go ? cfg_fast : fast_q),
    .div      (go ? cfg_div : div_q),
    .rise     (rise),
    .slot_end (slot_end),
    .clk_hi   (clk_hi)
  );

  swd_seq #(.TURN_W(TURN_W), .IDLE_W(IDLE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_ap     (req_ap),
    .req_rnw    (req_rnw),
    .req_addr   (req_addr),
    .req_ts     (req_ts),
    .wdata      (wdata),
    .cfg_turn   (cfg_turn),
    .cfg_idle   (cfg_idle),
    .cfg_dphase (cfg_dphase),
    .rise       (rise),
    .slot_end   (slot_end),
    .din        (swdio_i),
    .go         (go),
    .busy       (busy),
    .drv_oe     (swdio_oe),
    .drv_o      (swdio_o),
    .done       (done),
    .resp       (resp),
    .rdata      (rdata),
    .ts_strobe  (ts_strobe)
  );

  assign swclk = !busy || clk_hi;

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swclk && swdio_oe && swdio_o));
  // R4
  released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swdio_oe |-> swdio_o);
  // R2
  first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !swclk);
  // R2
  sample_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !swclk);

endmodule

// File: tb/swd_xfer_engine_tb.sv
module swd_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_ap = 1'b0, req_rnw = 1'b0, req_ts = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  cfg_turn = '0;
  logic [7:0]  cfg_idle = '0;
  logic        cfg_dphase = 1'b0, cfg_fast = 1'b1;
  logic [7:0]  cfg_div = '0;
  logic        swdio_i = 1'b1;
  logic        swclk, swdio_o, swdio_oe, busy, done, ts_strobe;
  logic [3:0]  resp;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  typedef struct {
    bit    oe;
    bit    o;
    bit    din;
    string tag;
  } slot_t;
  slot_t sq[$];

  swd_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ap(req_ap),
    .req_rnw(req_rnw), .req_addr(req_addr), .req_ts(req_ts), .wdata(wdata),
    .cfg_turn(cfg_turn), .cfg_idle(cfg_idle), .cfg_dphase(cfg_dphase),
    .cfg_fast(cfg_fast), .cfg_div(cfg_div), .swdio_i(swdio_i),
    .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .busy(busy),
    .done(done), .resp(resp), .rdata(rdata), .ts_strobe(ts_strobe)
  );

  always #4 clk = !clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic add(input bit oe, input bit o, input bit din, input string tag);
    slot_t s;
    s.oe = oe; s.o = o; s.din = din; s.tag = tag;
    sq.push_back(s);
  endtask

  // expected slot list, built from the requirements
  task automatic build(input bit ap, input bit rnw, input bit [1:0] a,
                       input bit [31:0] wd, input bit [2:0] ack,
                       input bit [31:0] td, input bit flip,
                       input int t, input int idle, input bit dph);
    bit p;
    bit [7:0] rq;
    sq.delete();
    p  = ap ^ rnw ^ a[0] ^ a[1];
    rq = {1'b1, 1'b0, p, a[1], a[0], rnw, ap, 1'b1};
    for (int i = 0; i < 8; i++) add(1, rq[i], 1, "R3");
    for (int i = 0; i < t; i++) add(0, 1, 1, "R4");
    for (int i = 0; i < 3; i++) add(0, 1, ack[i], "R4");
    if (ack == 3'b001) begin
      if (rnw) begin
        for (int i = 0; i < 32; i++) add(0, 1, td[i], "R5");
        add(0, 1, (^td) ^ flip, "R6");
        for (int i = 0; i < t; i++) add(0, 1, 1, "R5");
      end else begin
        for (int i = 0; i < t; i++) add(0, 1, 1, "R7");
        for (int i = 0; i < 32; i++) add(1, wd[i], 1, "R7");
        add(1, ^wd, 1, "R7");
      end
      for (int i = 0; i < idle; i++) add(1, 0, 1, "R8");
    end else if (ack == 3'b010 || ack == 3'b100) begin
      if (dph && rnw) for (int i = 0; i < 33; i++) add(0, 1, 1, "R9");
      for (int i = 0; i < t; i++) add(0, 1, 1, dph ? "R9" : "R11");
      if (dph && !rnw) for (int i = 0; i < 33; i++) add(1, 0, 1, "R10");
    end else begin
      for (int i = 0; i < t + 33; i++) add(0, 1, 1, "R12");
    end
  endtask

  task automatic xfer(input bit ap, input bit rnw, input bit [1:0] a, input bit ts,
                      input bit [31:0] wd, input bit [2:0] ack, input bit [31:0] td,
                      input bit flip, input int t, input int idle, input bit dph,
                      input bit fast, input int div, input bit poke);
    int h;
    bit ok;
    logic [3:0] eresp;
    logic [31:0] prev_rdata;
    h  = fast ? 1 : div + 2;
    ok = (ack == 3'b001);
    build(ap, rnw, a, wd, ack, td, flip, t, idle, dph);
    eresp = (ok && rnw && flip) ? 4'b1000 : {1'b0, ack};
    prev_rdata = rdata;
    req_ap = ap; req_rnw = rnw; req_addr = a; req_ts = ts; wdata = wd;
    cfg_turn = 2'(t - 1); cfg_idle = 8'(idle); cfg_dphase = dph;
    cfg_fast = fast; cfg_div = 8'(div);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < sq.size(); s++) begin
      for (int c = 0; c < 2 * h; c++) begin
        swdio_i = sq[s].din;
        if (poke && s == 12 && c == 0) begin
          start = 1'b1; req_rnw = !rnw; req_ap = !ap; wdata = ~wd; cfg_turn = 2'd3;
        end else begin
          start = 1'b0;
        end
        // R2 timing, plus per-slot drive of the owning requirement
        chk(sq[s].tag, {28'd0, swclk, busy, swdio_oe, swdio_o},
            {28'd0, (c >= h) ? 1'b1 : 1'b0, 1'b1, sq[s].oe, sq[s].o});
        @(negedge clk);
      end
    end
    swdio_i = 1'b1;
    start = 1'b0;
    chk("R13", {28'd0, done, busy, swclk, swdio_oe}, {28'd0, 4'b1011});
    chk((eresp == 4'b1000) ? "R6" : "R4", {28'd0, resp}, {28'd0, eresp});
    chk("R5", rdata, (ok && rnw) ? td : prev_rdata);
    chk("R14", {31'd0, ts_strobe}, {31'd0, ok && ts});
    @(negedge clk);
    chk("R13", {30'd0, done, ts_strobe}, 32'd0);
    chk("R1", {29'd0, swclk, swdio_oe, swdio_o}, {29'd0, 3'b111});
    chk("R13", {28'd0, resp}, {28'd0, eresp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {28'd0, swclk, busy, swdio_oe, swdio_o}, {28'd0, 4'b1011});
    chk("R1", {27'd0, done, resp}, 32'd0);
    chk("R1", rdata, 32'd0);
    // OK read, fast, ts set
    xfer(1, 1, 2'b10, 1, 32'h0, 3'b001, 32'hA5C3_1E70, 0, 1, 0, 0, 1, 0, 0);
    // OK read, parity flipped, slow rate (R2, R6)
    xfer(0, 1, 2'b01, 0, 32'h0, 3'b001, 32'h0000_F00D, 1, 2, 2, 0, 0, 1, 0);
    // OK write with idle, ts set
    xfer(0, 0, 2'b11, 1, 32'h8000_0001, 3'b001, 32'h0, 0, 3, 4, 0, 1, 0, 0);
    // WAIT read, dummy phase
    xfer(1, 1, 2'b00, 1, 32'h0, 3'b010, 32'h0, 0, 1, 5, 1, 1, 0, 0);
    // FAULT write, dummy phase, idle not applied
    xfer(1, 0, 2'b10, 0, 32'h1234_5678, 3'b100, 32'h0, 0, 2, 3, 1, 0, 0, 0);
    // WAIT write, no dummy (R11)
    xfer(0, 0, 2'b01, 0, 32'hFFFF_0000, 3'b010, 32'h0, 0, 4, 2, 0, 1, 0, 0);
    // FAULT read, no dummy (R11)
    xfer(1, 1, 2'b11, 0, 32'h0, 3'b100, 32'hDEAD_BEEF, 0, 2, 0, 0, 1, 0, 0);
    // protocol errors (R12)
    xfer(0, 1, 2'b00, 1, 32'h0, 3'b111, 32'h0, 0, 1, 2, 1, 1, 0, 0);
    xfer(1, 0, 2'b01, 0, 32'h0, 3'b000, 32'h0, 0, 3, 0, 0, 0, 1, 0);
    // OK write with start poked mid-transfer (R13), slow, ts (R14)
    xfer(1, 0, 2'b10, 1, 32'h3C3C_0FF1, 3'b001, 32'h0, 0, 2, 1, 0, 0, 0, 1);
    // OK read after write keeps read path, idle slots (R8)
    xfer(0, 1, 2'b11, 0, 32'h0, 3'b001, 32'h7FFF_FFFE, 0, 4, 3, 1, 1, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule